// File: doc/BRIEF.md
# Bit-Serial Multiply-Accumulate Memory Tile

This block is a dual-port memory tile of 32-bit words with four bit-serial multiply-accumulate engines and a small sequencer attached. While compute mode is off, port A is an ordinary byte-masked write port. While compute mode is on, a port A write is an instruction instead of a store. It carries four packed activations in its data word and a precision code in its byte-enable field. It names a weight word by its address, and one address bit asks for all accumulators to be cleared first. Port B is a registered read port. It returns either a memory word or one accumulator result, and it serves a read in every cycle, including the cycles in which the engines are computing.

The sequencer has three states. In `S_IDLE` it waits; an accepted instruction moves it to `S_FETCH` (transition *accept*). `S_FETCH` reads the weight word, loads each engine's byte lane and applies the optional clear, then always moves on to `S_COMP` (transition *fetched*). `S_COMP` takes one cycle per activation bit, most significant bit first. When the last bit (bit 0) has been accumulated, it returns to `S_IDLE` (transition *done*). Each engine treats its weight byte as one, two or four signed weights, depending on the configured weight precision, and keeps a separate sub-accumulator for each of them.

Top module: `cim_tile_seq`

## Requirements
- R1: With `cfg_cim_en`=0 and `busy`=0, a port A write stores byte lane i (bits 8i+7..8i) of `a_wdata` into word `a_addr` only where `a_be[i]`=1; all other bytes keep their old value.
- R2: With `b_sel`=0, `b_rdata` shows memory word `b_addr` one clock after the address is presented, in every cycle, including while `busy`=1.
- R3: With `cfg_cim_en`=1 and `busy`=0, a port A write is an instruction and writes no memory. Byte lane i of `a_wdata` is the activation for engine i. Only its low n bits are used, as a two's-complement value with bit n-1 as the sign. The weight word is taken from address {0, `a_addr`[ADDR_W-2:0]}.
- R4: The activation bit count n is `a_be` when `a_be` is 2 to 8, and 8 for any other `a_be` value.
- R5: Weight precision is set by `cfg_wprec`: 0 gives 2 bits, 1 gives 4 bits, and 2 or 3 give 8 bits. Byte lane i of the weight word belongs to engine i. It holds 8/w signed weights, and weight j occupies bits j*w+w-1..j*w of that lane. Sub-accumulators whose j has no weight are left unchanged.
- R6: Each instruction adds the signed product of activation i and weight j into accumulator (i, j). Results add onto earlier instructions unless a clear is requested.
- R7: When `a_addr`[ADDR_W-1]=1 in an instruction, all sixteen accumulators are set to zero before the instruction's products are added.
- R8: `busy` is high for exactly n+1 clock cycles, starting in the cycle after the accepting edge. The final results are readable once `busy` is low.
- R9: A port A write while `busy`=1 is ignored: it writes no memory and does not start an instruction. It sets `err`, which then stays high until reset.
- R10: With `b_sel`=1, `b_rdata` shows accumulator (engine `b_addr`[3:2], sub `b_addr`[1:0]), sign-extended to 32 bits, one clock later.
- R11: After reset, `busy`=0, `err`=0, `b_rdata`=0 and every accumulator reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tile clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cim_en | input | 1 | 1 = port A writes are compute instructions |
| cfg_wprec | input | 2 | Weight precision code |
| a_we | input | 1 | Port A write strobe |
| a_addr | input | ADDR_W | Port A address; MSB is the clear bit in compute mode |
| a_wdata | input | 32 | Port A data or packed activations |
| a_be | input | 4 | Byte enables or activation precision |
| b_sel | input | 1 | Port B source: 0 memory, 1 accumulator |
| b_addr | input | ADDR_W | Port B address or accumulator index |
| b_rdata | output | 32 | Registered port B read data |
| busy | output | 1 | Instruction in progress |
| err | output | 1 | Sticky flag: write arrived while busy |

## Verification
The bench builds the tile with ADDR_W=6 and ACC_W=20. The 6-bit address gives 32 weight words below the clear bit, and it leaves enough low address bits to index all sixteen accumulators. A 20-bit accumulator is wide enough that several full 8-bit by 8-bit products can be summed without wrapping. This makes it possible to check, against a reference model, that results accumulate across instructions, that the sign-bit subtraction is right at the most negative activation and weight values, and that all three weight packings behave correctly.

// File: rtl/cim_pkg.sv
package cim_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_COMP  = 2'd2
    } seq_state_e;

    // activation bit count from the byte-enable field
    function automatic logic [3:0] prec_bits(input logic [3:0] code);
        if (code >= 4'd2 && code <= 4'd8) return code;
        return 4'd8;
    endfunction

    // signed weight j of an 8-bit lane, sign-extended to 8 bits; 0 if absent
    function automatic logic [7:0] wsel(input logic [7:0] lane,
                                        input logic [1:0] code,
                                        input logic [1:0] j);
        logic [1:0] f2;
        logic [3:0] f4;
        case (code)
            2'd0: begin
                f2 = lane[{j, 1'b0} +: 2];
                return {{6{f2[1]}}, f2};
            end
            2'd1: begin
                f4 = lane[{j[0], 2'b00} +: 4];
                return (j[1] == 1'b0) ? {{4{f4[3]}}, f4} : 8'd0;
            end
            default: return (j == 2'd0) ? lane : 8'd0;
        endcase
    endfunction

endpackage

// File: rtl/cim_mem.sv
module cim_mem #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [3:0]        wr_be,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic [ADDR_W-1:0] fe_addr,
    output logic [31:0]       fe_data
);
    localparam int DEPTH = 2 ** ADDR_W;
    localparam int NB    = 4;

    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < NB; b++) begin
                if (wr_be[b]) mem[wr_addr][b*8 +: 8] <= wr_data[b*8 +: 8];
            end
        end
    end

    assign rd_data = mem[rd_addr];
    assign fe_data = mem[fe_addr];
endmodule

// File: rtl/cim_seq.sv
module cim_seq
    import cim_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NPE    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cim_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [31:0]       a_wdata,
    input  logic [3:0]        a_be,
    input  logic [1:0]        cfg_wprec,
    output logic              busy,
    output logic              err,
    output logic              mem_we,
    output logic              fetch_en,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              acc_clr,
    output logic              step_en,
    output logic              neg_step,
    output logic [2:0]        bit_pos,
    output logic [NPE-1:0]    act_bits,
    output logic [1:0]        wcode
);
    seq_state_e state, state_nx;

    logic [31:0]       act_q;
    logic [3:0]        nbits_q;
    logic [ADDR_W-2:0] addr_q;
    logic              clr_q;
    logic [2:0]        bit_q;
    logic [1:0]        wcode_q;
    logic              err_q;
    logic              accept, reject;

    assign accept = a_we && cim_en && (state == S_IDLE);
    assign reject = a_we && (state != S_IDLE);
    assign mem_we = a_we && !cim_en && (state == S_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (accept) state_nx = S_FETCH;
            S_FETCH: state_nx = S_COMP;
            S_COMP:  if (bit_q == 3'd0) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // instruction latches and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= '0;
            nbits_q <= 4'd8;
            addr_q  <= '0;
            clr_q   <= 1'b0;
            bit_q   <= '0;
            wcode_q <= 2'd2;
            err_q   <= 1'b0;
        end else begin
            if (reject) err_q <= 1'b1;
            if (accept) begin
                act_q   <= a_wdata;
                nbits_q <= prec_bits(a_be);
                addr_q  <= a_addr[ADDR_W-2:0];
                clr_q   <= a_addr[ADDR_W-1];
                wcode_q <= cfg_wprec;
            end
            if (state == S_FETCH)     bit_q <= 3'(nbits_q - 4'd1);
            else if (state == S_COMP) bit_q <= bit_q - 3'd1;
        end
    end

    // outputs
    always_comb begin
        busy     = 1'b0;
        fetch_en = 1'b0;
        step_en  = 1'b0;
        unique case (state)
            S_IDLE:  ;
            S_FETCH: begin busy = 1'b1; fetch_en = 1'b1; end
            S_COMP:  begin busy = 1'b1; step_en  = 1'b1; end
            default: ;
        endcase
    end

    assign acc_clr    = fetch_en && clr_q;
    assign neg_step   = step_en && ({1'b0, bit_q} == nbits_q - 4'd1);
    assign bit_pos    = bit_q;
    assign fetch_addr = {1'b0, addr_q};
    assign wcode      = wcode_q;
    assign err        = err_q;

    for (genvar g = 0; g < NPE; g++) begin : g_bit
        logic [7:0] lane;
        assign lane        = act_q[g*8 +: 8];
        assign act_bits[g] = lane[bit_q];
    end
endmodule

// File: rtl/cim_pe.sv
module cim_pe
    import cim_pkg::*;
#(
    parameter int ACC_W = 20,
    parameter int NSUB  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_w,
    input  logic [7:0]                 lane_in,
    input  logic [1:0]                 wcode,
    input  logic                       clr,
    input  logic                       step,
    input  logic                       abit,
    input  logic                       neg,
    input  logic [2:0]                 pos,
    output logic [NSUB-1:0][ACC_W-1:0] acc_o
);
    logic [7:0]                 lane_q;
    logic [NSUB-1:0][ACC_W-1:0] term;

    for (genvar j = 0; j < NSUB; j++) begin : g_term
        logic [7:0]       wv;
        logic [ACC_W-1:0] wext;
        assign wv      = wsel(lane_q, wcode, 2'(j));
        assign wext    = {{(ACC_W-8){wv[7]}}, wv};
        assign term[j] = wext << pos;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
            acc_o  <= '0;
        end else begin
            if (load_w) lane_q <= lane_in;
            if (clr) begin
                acc_o <= '0;
            end else if (step && abit) begin
                for (int j = 0; j < NSUB; j++) begin
                    acc_o[j] <= neg ? acc_o[j] - term[j] : acc_o[j] + term[j];
                end
            end
        end
    end
endmodule

// File: rtl/cim_tile_seq.sv
module cim_tile_seq #(
    parameter int ADDR_W = 6,
    parameter int ACC_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cim_en,
    input  logic [1:0]        cfg_wprec,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [31:0]       a_wdata,
    input  logic [3:0]        a_be,
    input  logic              b_sel,
    input  logic [ADDR_W-1:0] b_addr,
    output logic [31:0]       b_rdata,
    output logic              busy,
    output logic              err
);
    localparam int DATA_W = 32;
    localparam int NPE    = DATA_W / 8;
    localparam int NSUB   = 4;

    logic              mem_we, fetch_en, acc_clr, step_en, neg_step;
    logic [ADDR_W-1:0] fetch_addr;
    logic [2:0]        bit_pos;
    logic [NPE-1:0]    act_bits;
    logic [1:0]        wcode;
    logic [31:0]       mem_rd, fe_data;
    logic [NPE-1:0][NSUB-1:0][ACC_W-1:0] acc_all;
    logic [ACC_W-1:0]  acc_sel;

    cim_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .wr_en(mem_we), .wr_addr(a_addr), .wr_data(a_wdata),
        .wr_be(a_be), .rd_addr(b_addr), .rd_data(mem_rd),
        .fe_addr(fetch_addr), .fe_data(fe_data)
    );

    cim_seq #(.ADDR_W(ADDR_W), .NPE(NPE)) u_seq (
        .clk(clk), .rst_n(rst_n), .cim_en(cfg_cim_en), .a_we(a_we),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_be(a_be), .cfg_wprec(cfg_wprec),
        .busy(busy), .err(err), .mem_we(mem_we), .fetch_en(fetch_en),
        .fetch_addr(fetch_addr), .acc_clr(acc_clr), .step_en(step_en),
        .neg_step(neg_step), .bit_pos(bit_pos), .act_bits(act_bits),
        .wcode(wcode)
    );

    for (genvar g = 0; g < NPE; g++) begin : g_pe
        cim_pe #(.ACC_W(ACC_W), .NSUB(NSUB)) u_pe (
            .clk(clk), .rst_n(rst_n), .load_w(fetch_en),
            .lane_in(fe_data[g*8 +: 8]), .wcode(wcode), .clr(acc_clr),
            .step(step_en), .abit(act_bits[g]), .neg(neg_step),
            .pos(bit_pos), .acc_o(acc_all[g])
        );
    end

    assign acc_sel = acc_all[b_addr[3:2]][b_addr[1:0]];

    always_ff @(posedge clk) begin
        if (!rst_n)     b_rdata <= '0;
        else if (b_sel) b_rdata <= {{(DATA_W-ACC_W){acc_sel[ACC_W-1]}}, acc_sel};
        else            b_rdata <= mem_rd;
    end
endmodule

// File: rtl/cim_tile_seq_chk.sv
module cim_tile_seq_chk
    import cim_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_cim_en,
    input logic       a_we,
    input logic [3:0] a_be,
    input logic       busy,
    input logic       err
);
    logic [3:0] exp_len;
    logic [3:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_len <= '0;
            cnt     <= '0;
        end else if (!busy && a_we && cfg_cim_en) begin
            exp_len <= prec_bits(a_be) + 4'd1;
            cnt     <= '0;
        end else if (busy) begin
            cnt <= cnt + 4'd1;
        end
    end

    AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && a_we && cfg_cim_en) |=> busy);                      // R3
    AST_NORMAL_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && a_we && !cfg_cim_en) |=> !busy);                    // R1
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt < exp_len));                                    // R8
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (cnt == exp_len));                            // R4
    AST_ERR_ON_BUSY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && a_we) |=> err);                                      // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);                                                 // R9
endmodule

bind cim_tile_seq cim_tile_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_cim_en(cfg_cim_en), .a_we(a_we),
    .a_be(a_be), .busy(busy), .err(err)
);

// File: tb/test_cim_tile_seq.sv
module test_cim_tile_seq;
    localparam int ADDR_W = 6;
    localparam int ACC_W  = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_cim_en = 1'b0;
    logic [1:0]        cfg_wprec = 2'd2;
    logic              a_we = 1'b0;
    logic [ADDR_W-1:0] a_addr = '0;
    logic [31:0]       a_wdata = '0;
    logic [3:0]        a_be = '0;
    logic              b_sel = 1'b0;
    logic [ADDR_W-1:0] b_addr = '0;
    logic [31:0]       b_rdata;
    logic              busy, err;

    int total = 0;
    int bad   = 0;
    logic [31:0] mem_m [64];
    int          acc_m [16];

    cim_tile_seq #(.ADDR_W(ADDR_W), .ACC_W(ACC_W)) i_cim_tile_seq (
        .clk(clk), .rst_n(rst_n), .cfg_cim_en(cfg_cim_en), .cfg_wprec(cfg_wprec),
        .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_be(a_be),
        .b_sel(b_sel), .b_addr(b_addr), .b_rdata(b_rdata), .busy(busy), .err(err)
    );

    always #5 clk = ~clk;

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int prec(input logic [3:0] be);
        return (be >= 2 && be <= 8) ? int'(be) : 8;
    endfunction

    function automatic int sx(input int v, input int n);
        return (v >= (1 << (n - 1))) ? v - (1 << n) : v;
    endfunction

    function automatic int act_val(input logic [7:0] b, input int n);
        return sx(int'(b) & ((1 << n) - 1), n);
    endfunction

    function automatic int wgt(input logic [7:0] lane, input int wp, input int j);
        int wb = (wp == 0) ? 2 : (wp == 1) ? 4 : 8;
        if (j >= 8 / wb) return 0;
        return sx((int'(lane) >> (j * wb)) & ((1 << wb) - 1), wb);
    endfunction

    task automatic write_mem(input int addr, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        cfg_cim_en = 1'b0; a_we = 1'b1; a_addr = ADDR_W'(addr); a_wdata = d; a_be = be;
        @(negedge clk);
        a_we = 1'b0;
        for (int b = 0; b < 4; b++) if (be[b]) mem_m[addr][b*8 +: 8] = d[b*8 +: 8];
    endtask

    task automatic read_b(input bit s, input int addr, output logic [31:0] v);
        @(negedge clk);
        b_sel = s; b_addr = ADDR_W'(addr);
        @(negedge clk);
        v = b_rdata;
    endtask

    task automatic check_accs(input string tag);
        logic [31:0] v;
        for (int k = 0; k < 16; k++) begin
            read_b(1'b1, k, v);
            check(v == 32'(acc_m[k]), tag, v, 32'(acc_m[k]));
        end
    endtask

    // issue one instruction; port B memory reads run during the busy window
    task automatic do_instr(input int addr, input bit clr, input logic [31:0] acts,
                            input logic [3:0] be, input bit intrude, input string tag);
        int n = prec(be);
        int cnt = 0;
        int rk = 0;
        logic [31:0] w = mem_m[addr];
        @(negedge clk);
        cfg_cim_en = 1'b1; a_we = 1'b1; a_addr = {clr, 5'(addr)}; a_wdata = acts; a_be = be;
        @(negedge clk);
        a_we = 1'b0;
        if (busy) cnt = 1;
        while (busy && cnt < 20) begin
            if (intrude && cnt == 1) begin
                a_we = 1'b1; cfg_cim_en = 1'b0; a_addr = 6'd10;
                a_wdata = 32'hDEAD_BEEF; a_be = 4'hF;
            end
            b_sel = 1'b0; b_addr = ADDR_W'(rk);
            @(negedge clk);
            a_we = 1'b0; cfg_cim_en = 1'b1;
            check(b_rdata == mem_m[rk], "R2 port B read during compute", b_rdata, mem_m[rk]);
            rk = (rk + 1) % 4;
            if (busy) cnt++;
        end
        check(cnt == n + 1, {tag, " R8 busy length"}, 32'(cnt), 32'(n + 1));
        if (clr) for (int k = 0; k < 16; k++) acc_m[k] = 0;
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
                acc_m[i*4+j] += act_val(acts[i*8 +: 8], n) * wgt(w[i*8 +: 8], int'(cfg_wprec), j);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check(busy == 1'b0, "R11 busy after reset", 32'(busy), 0);
        check(err == 1'b0, "R11 err after reset", 32'(err), 0);
        check(b_rdata == 32'd0, "R11 b_rdata after reset", b_rdata, 0);
        for (int k = 0; k < 16; k++) acc_m[k] = 0;
        check_accs("R11 accumulator after reset");
        read_b(1'b1, 5, v);
        check(v == 32'd0, "R11 accumulator 5", v, 0);
    endtask

    task automatic t_mem;
        logic [31:0] v;
        write_mem(0, 32'h0102_0304, 4'hF);
        write_mem(1, 32'hA5A5_5A5A, 4'hF);
        write_mem(2, 32'hFFFF_0000, 4'hF);
        write_mem(3, 32'h1357_9BDF, 4'hF);
        for (int k = 0; k < 4; k++) begin
            read_b(1'b0, k, v);
            check(v == mem_m[k], "R1 R2 full word write", v, mem_m[k]);
        end
        write_mem(1, 32'h1122_3344, 4'b0101);
        read_b(1'b0, 1, v);
        check(v == 32'hA522_5A44, "R1 byte-masked write", v, 32'hA522_5A44);
    endtask

    task automatic t_mac_w8;
        logic [31:0] v;
        write_mem(4, 32'h807F_03FE, 4'hF);
        cfg_wprec = 2'd2;
        do_instr(4, 1'b1, 32'hFF01_7F85, 4'd8, 1'b0, "R6 w8");
        check_accs("R3 R5 R6 8-bit weights");
        read_b(1'b0, 4, v);
        check(v == 32'h807F_03FE, "R3 instruction writes no memory", v, 32'h807F_03FE);
        write_mem(5, 32'h8080_8080, 4'hF);
        do_instr(5, 1'b0, 32'h8080_8080, 4'd8, 1'b0, "R6 extremes");
        check_accs("R6 accumulate most negative values");
    endtask

    task automatic t_mac_w4;
        write_mem(6, 32'h7F18_E98C, 4'hF);
        cfg_wprec = 2'd1;
        do_instr(6, 1'b0, 32'h3CA9_5F48, 4'd4, 1'b0, "R4 n=4");
        check_accs("R5 R6 4-bit weights, upper activation bits ignored");
    endtask

    task automatic t_clear_w2;
        write_mem(7, 32'h1BE4_72C9, 4'hF);
        cfg_wprec = 2'd0;
        do_instr(7, 1'b1, 32'hF206_0D55, 4'd3, 1'b0, "R4 n=3");
        check_accs("R7 R5 clear then 2-bit weights");
    endtask

    task automatic t_prec_codes;
        cfg_wprec = 2'd3;
        do_instr(5, 1'b0, 32'h0281_7E33, 4'd0, 1'b0, "R4 code 0");
        check_accs("R4 code 0 treated as 8 bits");
        do_instr(4, 1'b0, 32'h1234_5678, 4'hF, 1'b0, "R4 code 15");
        check_accs("R4 code 15 treated as 8 bits");
        cfg_wprec = 2'd1;
        do_instr(6, 1'b1, 32'h0302_0100, 4'd2, 1'b0, "R4 code 2");
        check_accs("R4 R7 two-bit activations");
    endtask

    task automatic t_busy_write;
        logic [31:0] v;
        write_mem(10, 32'h1234_5678, 4'hF);
        check(err == 1'b0, "R9 err low before busy write", 32'(err), 0);
        cfg_wprec = 2'd2;
        do_instr(4, 1'b0, 32'h0507_F9FD, 4'd6, 1'b1, "R9 intruded");
        check(err == 1'b1, "R9 err set by busy write", 32'(err), 1);
        read_b(1'b0, 10, v);
        check(v == 32'h1234_5678, "R9 busy write stored nothing", v, 32'h1234_5678);
        check_accs("R9 busy write started no instruction");
        do_instr(5, 1'b0, 32'h0101_0101, 4'd8, 1'b0, "R9 after");
        check(err == 1'b1, "R9 err stays set", 32'(err), 1);
        check_accs("R10 results after later instruction");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mem();
        t_mac_w8();
        t_mac_w4();
        t_clear_w2();
        t_prec_codes();
        t_busy_write();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule